// File: doc/BRIEF.md
# Two-Channel DMA Command Controller

This block keeps the run state of a DMA with two channels and applies the Stop, Start and Clear commands that software writes to a chosen channel. Each channel is always in one of five states: Idle, Queued, Running, Complete or Error. Only one channel may be Running at a time. A channel started while the other is busy waits in Queued and is promoted on its own once the other channel stops being busy. A channel counts as busy while it is Queued or Running. It also counts as busy while it sits in Complete or Error with an address error flag still set.

The block does not move data. It sends one-cycle start and stop requests to an external transfer engine. The engine sends back a report when a channel's outstanding accesses have drained, and that report carries two error flags, one for the internal side and one for the external side. Reports are always accepted, with no back-pressure. A report that arrives for a channel that is not Running is dropped. Every command write passes a permission check, which uses the security state, the privilege level, a non-secure enable bit and the selected channel's user enable bit. Reads and reserved operations are always refused. The block has no debug-halt input, so a debug halt never stops a channel on its own.

Top module: `dma_cmd_ctrl`

## Requirements
- R1: After reset both channels are Idle (code 0), and all interrupts, error flags, start requests and stop requests are 0.
- R2: `cmd_undef` is 1 during a valid command in these cases: the access is a read; the operation is 3; the mode is non-secure and `ns_dma_en` is 0; the mode is user and the selected channel's `user_en` bit is 0. A refused command changes no state and sends no request.
- R3: Start (op 1) on a channel that is not in operation moves it to Running (code 2) when the other channel is not in operation, and `eng_start` for that channel is high for exactly the next cycle. Otherwise the channel moves to Queued (code 1). At most one channel is Running at a time.
- R4: A channel in Complete or Error with either error flag set counts as in operation, so a Start on the other channel queues.
- R5: Stop (op 0) on a Queued channel moves it to Idle and sends no request.
- R6: Stop on a Running channel pulses `eng_stop` for one cycle and leaves the channel Running. A later engine report moves it to Error (code 4) if either report flag is set, latching those flags, and to Complete (code 3) if neither is set.
- R7: Stop on an Idle, Complete or Error channel has no effect, and Clear on a Running or Queued channel has no effect.
- R8: Clear (op 2) on a Complete or Error channel moves it to Idle and clears its interrupt and both of its error flags.
- R9: A Queued channel becomes Running one cycle after the other channel leaves the in-operation set, and it pulses `eng_start`. If a Start on the other channel lands in that same cycle, the promotion wins and the newly started channel goes to Queued.
- R10: A channel's interrupt rises when the channel enters Complete or Error.
- R11: Start on a channel that is in operation is ignored. Start from Complete clears that channel's interrupt.
- R12: An engine report for a channel that is not Running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command access is present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_op | input | 2 | 0 Stop, 1 Start, 2 Clear, 3 reserved |
| cmd_ch | input | 1 | Selected channel |
| cpu_nonsecure | input | 1 | 1 = non-secure state |
| cpu_user | input | 1 | 1 = user mode, 0 = privileged |
| ns_dma_en | input | 1 | Non-secure access enable |
| user_en | input | 2 | Per-channel user access enable |
| cmd_undef | output | 1 | Command refused (undefined-instruction exception) |
| eng_start | output | 2 | One-cycle start request per channel |
| eng_stop | output | 2 | One-cycle stop request per channel |
| eng_rpt_valid | input | 1 | Engine report that a channel has drained |
| eng_rpt_ch | input | 1 | Channel of the report |
| eng_rpt_err_int | input | 1 | Internal address error in the report |
| eng_rpt_err_ext | input | 1 | External address error in the report |
| ch_state | output | 6 | 3-bit state code per channel, channel c at bits [3c+2:3c] |
| err_int | output | 2 | Latched internal error flag per channel |
| err_ext | output | 2 | Latched external error flag per channel |
| irq | output | 2 | Completion or error interrupt per channel |

## Verification
Two events can fall in the same cycle. One is the automatic promotion of a Queued channel. The other is a software Start on the channel that has just finished. The bench provokes this by sending a clean completion report for the running channel and then, on the very next cycle, a Start on that channel. It checks that the waiting channel runs with a start request, that the restarted channel lands in Queued with its interrupt cleared, and that the two channels never run together. A refused Stop on a Running channel is also placed next to live engine traffic, and the bench checks that no stop request leaks out.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;
  localparam int NCH  = 2;
  localparam int CH_W = 1;
  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    CH_IDLE     = 3'd0,
    CH_QUEUED   = 3'd1,
    CH_RUNNING  = 3'd2,
    CH_COMPLETE = 3'd3,
    CH_ERROR    = 3'd4
  } ch_state_e;

  typedef enum logic [1:0] {
    OP_STOP  = 2'd0,
    OP_START = 2'd1,
    OP_CLEAR = 2'd2,
    OP_RSVD  = 2'd3
  } cmd_op_e;

  typedef struct packed {
    logic stop;
    logic start;
    logic clear;
  } ch_cmd_t;
endpackage

// File: rtl/dma_access_gate.sv
module dma_access_gate
  import dma_cmd_pkg::*;
(
  input  logic       cmd_valid,
  input  logic       cmd_write,
  input  logic [1:0] cmd_op,
  input  logic       cpu_nonsecure,
  input  logic       cpu_user,
  input  logic       ns_dma_en,
  input  logic       sel_user_en,
  output logic       cmd_ok,
  output logic       cmd_undef
);
  logic world_ok;
  logic level_ok;
  logic op_ok;

  always_comb begin
    world_ok  = !cpu_nonsecure || ns_dma_en;
    level_ok  = !cpu_user || sel_user_en;
    op_ok     = (cmd_op != OP_RSVD);
    cmd_ok    = cmd_valid && cmd_write && op_ok && world_ok && level_ok;
    cmd_undef = cmd_valid && !cmd_ok;
  end
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ch_cmd_t   cmd,
  input  logic      other_busy,
  input  logic      rpt_valid,
  input  logic      rpt_err_int,
  input  logic      rpt_err_ext,
  output ch_state_e state,
  output logic      in_op,
  output logic      irq,
  output logic      err_int,
  output logic      err_ext,
  output logic      eng_start,
  output logic      eng_stop
);
  ch_state_e nxt_state;
  logic nxt_irq, nxt_ei, nxt_ee, nxt_start, nxt_stop;
  logic done_state;

  always_comb begin
    done_state = (state == CH_COMPLETE) || (state == CH_ERROR);
    in_op = (state == CH_QUEUED) || (state == CH_RUNNING) ||
            (done_state && (err_int || err_ext));
  end

  always_comb begin
    nxt_state = state;
    nxt_irq   = irq;
    nxt_ei    = err_int;
    nxt_ee    = err_ext;
    nxt_start = 1'b0;
    nxt_stop  = 1'b0;
    unique case (state)
      CH_QUEUED: begin
        if (cmd.stop) begin
          nxt_state = CH_IDLE;
        end else if (!other_busy) begin
          nxt_state = CH_RUNNING;
          nxt_start = 1'b1;
        end
      end
      CH_RUNNING: begin
        if (rpt_valid) begin
          nxt_irq = 1'b1;
          if (rpt_err_int || rpt_err_ext) begin
            nxt_state = CH_ERROR;
            nxt_ei    = rpt_err_int;
            nxt_ee    = rpt_err_ext;
          end else begin
            nxt_state = CH_COMPLETE;
          end
        end else if (cmd.stop) begin
          nxt_stop = 1'b1;
        end
      end
      default: begin
        if (cmd.start && !in_op) begin
          nxt_irq = 1'b0;
          if (other_busy) begin
            nxt_state = CH_QUEUED;
          end else begin
            nxt_state = CH_RUNNING;
            nxt_start = 1'b1;
          end
        end else if (cmd.clear && done_state) begin
          nxt_state = CH_IDLE;
          nxt_irq   = 1'b0;
          nxt_ei    = 1'b0;
          nxt_ee    = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CH_IDLE;
      irq       <= 1'b0;
      err_int   <= 1'b0;
      err_ext   <= 1'b0;
      eng_start <= 1'b0;
      eng_stop  <= 1'b0;
    end else begin
      state     <= nxt_state;
      irq       <= nxt_irq;
      err_int   <= nxt_ei;
      err_ext   <= nxt_ee;
      eng_start <= nxt_start;
      eng_stop  <= nxt_stop;
    end
  end

  assert_queued_stop_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CH_QUEUED && cmd.stop) |=> (state == CH_IDLE && !eng_start && !eng_stop));

  assert_running_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CH_RUNNING && !rpt_valid) |=> (state == CH_RUNNING));

  assert_clear_wipes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_state && cmd.clear && !cmd.start) |=> (state == CH_IDLE && !irq && !err_int && !err_ext));

  assert_irq_on_finish_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CH_RUNNING && rpt_valid) |=> irq);
endmodule

// File: rtl/dma_cmd_ctrl.sv
module dma_cmd_ctrl
  import dma_cmd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic                cmd_write,
  input  logic [1:0]          cmd_op,
  input  logic [CH_W-1:0]     cmd_ch,
  input  logic                cpu_nonsecure,
  input  logic                cpu_user,
  input  logic                ns_dma_en,
  input  logic [NCH-1:0]      user_en,
  output logic                cmd_undef,
  output logic [NCH-1:0]      eng_start,
  output logic [NCH-1:0]      eng_stop,
  input  logic                eng_rpt_valid,
  input  logic [CH_W-1:0]     eng_rpt_ch,
  input  logic                eng_rpt_err_int,
  input  logic                eng_rpt_err_ext,
  output logic [NCH*ST_W-1:0] ch_state,
  output logic [NCH-1:0]      err_int,
  output logic [NCH-1:0]      err_ext,
  output logic [NCH-1:0]      irq
);
  logic            cmd_ok;
  logic [NCH-1:0]  in_op;
  ch_state_e       st [NCH];

  dma_access_gate u_gate (
    .cmd_valid     (cmd_valid),
    .cmd_write     (cmd_write),
    .cmd_op        (cmd_op),
    .cpu_nonsecure (cpu_nonsecure),
    .cpu_user      (cpu_user),
    .ns_dma_en     (ns_dma_en),
    .sel_user_en   (user_en[cmd_ch]),
    .cmd_ok        (cmd_ok),
    .cmd_undef     (cmd_undef)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int OTHER = i ^ 1;
    ch_cmd_t c_cmd;
    logic    sel;
    logic    rpt_hit;

    always_comb begin
      sel         = cmd_ok && (cmd_ch == CH_W'(i));
      c_cmd.stop  = sel && (cmd_op == OP_STOP);
      c_cmd.start = sel && (cmd_op == OP_START);
      c_cmd.clear = sel && (cmd_op == OP_CLEAR);
      rpt_hit     = eng_rpt_valid && (eng_rpt_ch == CH_W'(i));
    end

    dma_chan_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd         (c_cmd),
      .other_busy  (in_op[OTHER]),
      .rpt_valid   (rpt_hit),
      .rpt_err_int (eng_rpt_err_int),
      .rpt_err_ext (eng_rpt_err_ext),
      .state       (st[i]),
      .in_op       (in_op[i]),
      .irq         (irq[i]),
      .err_int     (err_int[i]),
      .err_ext     (err_ext[i]),
      .eng_start   (eng_start[i]),
      .eng_stop    (eng_stop[i])
    );

    assign ch_state[i*ST_W +: ST_W] = st[i];

    assert_start_req_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start[i] |-> (st[i] == CH_RUNNING));

    assert_stop_req_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eng_stop[i] |-> (st[i] == CH_RUNNING));
  end

  assert_single_runner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(st[0] == CH_RUNNING && st[1] == CH_RUNNING));

  assert_read_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write) |-> cmd_undef);
endmodule

// File: tb/tb_dma_cmd_ctrl.sv
module tb_dma_cmd_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_write = 1'b1;
  logic [1:0] cmd_op = 2'd0;
  logic       cmd_ch = 1'b0;
  logic       cpu_nonsecure = 1'b0, cpu_user = 1'b0, ns_dma_en = 1'b0;
  logic [1:0] user_en = 2'b00;
  logic       cmd_undef;
  logic [1:0] eng_start, eng_stop, err_int, err_ext, irq;
  logic       eng_rpt_valid = 1'b0, eng_rpt_ch = 1'b0;
  logic       eng_rpt_err_int = 1'b0, eng_rpt_err_ext = 1'b0;
  logic [5:0] ch_state;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_op(cmd_op), .cmd_ch(cmd_ch), .cpu_nonsecure(cpu_nonsecure),
    .cpu_user(cpu_user), .ns_dma_en(ns_dma_en), .user_en(user_en),
    .cmd_undef(cmd_undef), .eng_start(eng_start), .eng_stop(eng_stop),
    .eng_rpt_valid(eng_rpt_valid), .eng_rpt_ch(eng_rpt_ch),
    .eng_rpt_err_int(eng_rpt_err_int), .eng_rpt_err_ext(eng_rpt_err_ext),
    .ch_state(ch_state), .err_int(err_int), .err_ext(err_ext), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int st(input int c);
    return int'(ch_state[3*c +: 3]);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic cmd(input logic [1:0] op, input logic ch);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_op = op; cmd_ch = ch;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic rpt(input logic ch, input logic ei, input logic ee);
    @(negedge clk);
    eng_rpt_valid = 1'b1; eng_rpt_ch = ch;
    eng_rpt_err_int = ei; eng_rpt_err_ext = ee;
    @(posedge clk); #1;
    eng_rpt_valid = 1'b0; eng_rpt_err_int = 1'b0; eng_rpt_err_ext = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 ch_state", ch_state, 0);
    check("R1 irq", irq, 0);
    check("R1 err flags", {err_int, err_ext}, 0);
    check("R1 requests", {eng_start, eng_stop}, 0);

    // R2 sweep over modes, enables, direction and non-start ops on idle channels
    for (int m = 0; m < 64; m++) begin
      logic ns, us, db, ub, wr, ch;
      int exp_undef;
      ns = m[0]; us = m[1]; db = m[2]; ub = m[3]; wr = m[4]; ch = m[5];
      for (int k = 0; k < 3; k++) begin
        logic [1:0] op;
        op = (k == 0) ? 2'd0 : (k == 1) ? 2'd2 : 2'd3;
        @(negedge clk);
        cpu_nonsecure = ns; cpu_user = us; ns_dma_en = db;
        user_en = ch ? {ub, 1'b0} : {1'b0, ub};
        cmd_valid = 1'b1; cmd_write = wr; cmd_op = op; cmd_ch = ch;
        #1;
        exp_undef = (wr && op != 2'd3 && (!ns || db) && (!us || ub)) ? 0 : 1;
        check("R2 undef sweep", cmd_undef, exp_undef);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
      end
    end
    cmd_write = 1'b1; cpu_nonsecure = 1'b0; cpu_user = 1'b0; ns_dma_en = 1'b0; user_en = 2'b00;
    check("R7 idle unchanged after sweep", ch_state, 0);

    // R3 start runs
    cmd(2'd1, 1'b0);
    check("R3 ch0 running", st(0), 2);
    check("R3 start pulse", eng_start, 1);
    step();
    check("R3 start pulse one cycle", eng_start, 0);
    cmd(2'd1, 1'b1);
    check("R3 ch1 queued", st(1), 1);
    check("R3 no start for queued", eng_start, 0);
    cmd(2'd1, 1'b0);
    check("R11 restart ignored", st(0), 2);
    check("R11 no pulse", eng_start, 0);

    // R6 stop on running
    cmd(2'd0, 1'b0);
    check("R6 stop pulse", eng_stop, 1);
    check("R6 still running", st(0), 2);
    step();
    check("R6 stop pulse one cycle", eng_stop, 0);
    rpt(1'b0, 1'b0, 1'b0);
    check("R6 complete", st(0), 3);
    check("R10 irq ch0", irq, 1);
    check("R9 not yet promoted", st(1), 1);
    step();
    check("R9 promoted", st(1), 2);
    check("R9 promote pulse", eng_start, 2);

    // R8 clear
    cmd(2'd2, 1'b0);
    check("R8 cleared idle", st(0), 0);
    check("R8 irq cleared", irq, 0);

    // R5 stop on queued
    cmd(2'd1, 1'b0);
    check("R3 ch0 queued", st(0), 1);
    cmd(2'd0, 1'b0);
    check("R5 queued to idle", st(0), 0);
    check("R5 no requests", {eng_start, eng_stop}, 0);

    // R4 error holds the other channel
    rpt(1'b1, 1'b0, 1'b1);
    check("R6 error state", st(1), 4);
    check("R6 ext flag", err_ext, 2);
    check("R6 int flag", err_int, 0);
    check("R10 irq ch1", irq, 2);
    cmd(2'd1, 1'b0);
    check("R4 queued behind error", st(0), 1);
    step();
    check("R4 still queued", st(0), 1);
    cmd(2'd2, 1'b1);
    check("R8 error cleared", st(1), 0);
    check("R8 flags cleared", {err_int, err_ext}, 0);
    check("R8 irq cleared", irq, 0);
    step();
    check("R9 promoted after clear", st(0), 2);
    check("R9 pulse ch0", eng_start, 1);

    // R7 ineffective commands
    cmd(2'd2, 1'b0);
    check("R7 clear on running", st(0), 2);
    cmd(2'd0, 1'b1);
    check("R7 stop on idle", st(1), 0);
    check("R7 no stop pulse", eng_stop, 0);

    // R12 report on idle channel
    rpt(1'b1, 1'b1, 1'b1);
    check("R12 idle ignores report", st(1), 0);
    check("R12 no flags", {err_int, err_ext}, 0);
    check("R12 no irq", irq, 0);

    // R9 collision: promotion versus start on the finished channel
    cmd(2'd1, 1'b1);
    check("R3 ch1 queued", st(1), 1);
    rpt(1'b0, 1'b0, 1'b0);
    check("R6 ch0 complete", st(0), 3);
    check("R10 irq", irq, 1);
    cmd(2'd1, 1'b0);
    check("R9 promotion wins", st(1), 2);
    check("R9 starter queued", st(0), 1);
    check("R11 start clears irq", irq, 0);
    check("R9 pulse ch1", eng_start, 2);

    // R2 refused stop on running channel
    @(negedge clk);
    cpu_nonsecure = 1'b1; ns_dma_en = 1'b0;
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_ch = 1'b1;
    #1 check("R2 refused undef", cmd_undef, 1);
    @(posedge clk); #1 cmd_valid = 1'b0;
    check("R2 refused no stop", eng_stop, 0);
    check("R2 refused state kept", st(1), 2);
    ns_dma_en = 1'b1;
    cmd(2'd0, 1'b1);
    check("R6 stop ch1", eng_stop, 2);
    cpu_nonsecure = 1'b0; ns_dma_en = 1'b0;

    // R4 internal flag holds queued channel
    rpt(1'b1, 1'b1, 1'b0);
    check("R6 ch1 error", st(1), 4);
    check("R6 int flag", err_int, 2);
    step();
    check("R4 ch0 held", st(0), 1);
    cmd(2'd2, 1'b1);
    step();
    check("R9 ch0 runs", st(0), 2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule